// File: doc/BRIEF.md
# Multi-Channel Triggered-Update PWM Controller

This block holds six independent pulse-width modulated outputs behind a small memory-mapped register bus, with one clock and one synchronous reset. Each channel has a clock prescaler, a period counter and a high-time compare. Software writes land only in shadow registers. The waveform generator keeps running its last committed settings until the trigger bit of that channel rises. There is no enable bit. Software switches a channel off by committing a high time of zero.

A trigger rising edge captures the shadow settings of that channel: prescale, period, high time and polarity. If the smooth bit is set at that edge, the captured settings replace the running ones at the end of the current period, and the waveform has no glitch. If the smooth bit is clear, they replace the running ones after a fixed, parameterized latency, and the prescaler and period counters then start again from zero. While a channel has both its trigger bit and its smooth bit low, its output is held high.

Top module: `trig_pwm_ctrl`

## Requirements
- R1: After reset every register reads 0 and every PWM output is high.
- R2: Byte addresses: control at 0x00, with trigger in bit [c], polarity in bit [8+c], output type in bit [16+c] and smooth in bit [24+c] for channel c. Prescale at 0x04, with a 3-bit field at bits [4c+2:4c]. Period count at 0x08+8c and high-time count at 0x0C+8c, each in bits [23:0]. Each register reads back its implemented bits as last written. Unimplemented bits and unmapped addresses read 0. The output-type bit has no effect on the output.
- R3: With committed prescale s, period P (P at least 2), high time D and polarity 1, the output repeats every (s+1)*P clock cycles and is high for (s+1)*min(D,P) of them.
- R4: A committed period of 0 or 1, or a committed high time of 0, gives a constantly inactive output. A high time equal to or greater than the period gives a constantly active output.
- R5: Writes to prescale, period, high time or polarity leave the output unchanged until the trigger bit of that channel rises.
- R6: When smooth is 0 at a trigger rise, the output first reflects the new settings at the clock edge APPLY_LAT+2 after the edge that writes the trigger bit, and never earlier. The waveform then starts at the beginning of its active phase.
- R7: When smooth is 1 at a trigger rise, the new settings take over exactly at the end of the running period.
- R8: While trigger and smooth of a channel are both 0, its output is high from the next clock edge on. Setting either bit again, without a trigger rise, resumes the last committed waveform.
- R9: Polarity 1 gives an output that is high during the active phase. Polarity 0 inverts the waveform.
- R10: Channels are independent: committing or forcing one channel leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | 8 | Byte address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
A smooth-mode commit falls in the same cycle as the wrap of the period counter. The bench provokes this by starting a long zero-duty period with an immediate commit at a known edge. It then raises the trigger with smooth set part way through that period. It checks the output on every cycle, so it can confirm that the output stays low up to the exact wrap edge and is high from the next one. A second collision, a trigger edge that arrives while an earlier immediate commit is still counting down, is kept apart by the bench. The immediate-latency test counts cycles from the write edge, so a commit one cycle early or late is reported.

// File: rtl/trig_pwm_pkg.sv
package trig_pwm_pkg;

    localparam int CNT_W     = 24;
    localparam int PS_W      = 3;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int CTRL_ADDR = 0;
    localparam int PS_ADDR   = 4;
    localparam int CH_BASE   = 8;
    localparam int CH_STRIDE = 8;

    // Bit offsets of the per-channel fields inside the control word
    localparam int TRIG_OFS   = 0;
    localparam int POL_OFS    = 8;
    localparam int TYPE_OFS   = 16;
    localparam int SMOOTH_OFS = 24;

    typedef struct packed {
        logic [PS_W-1:0]  ps;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] duty;
        logic             pol;
    } wave_cfg_t;

    function automatic logic [ADDR_W-1:0] period_addr(input int c);
        return ADDR_W'(CH_BASE + CH_STRIDE * c);
    endfunction

    function automatic logic [ADDR_W-1:0] duty_addr(input int c);
        return ADDR_W'(CH_BASE + CH_STRIDE * c + 4);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_mask(input int nch);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int c = 0; c < nch; c++) begin
            m[TRIG_OFS + c]   = 1'b1;
            m[POL_OFS + c]    = 1'b1;
            m[TYPE_OFS + c]   = 1'b1;
            m[SMOOTH_OFS + c] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] ps_mask(input int nch);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int c = 0; c < nch; c++)
            for (int b = 0; b < PS_W; b++)
                m[4 * c + b] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/trig_pwm_regs.sv
module trig_pwm_regs
    import trig_pwm_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output logic [NCH-1:0]        trig,
    output logic [NCH-1:0]        smooth,
    output wave_cfg_t [NCH-1:0]   shadow
);

    localparam logic [DATA_W-1:0] CMASK = ctrl_mask(NCH);
    localparam logic [DATA_W-1:0] PMASK = ps_mask(NCH);

    logic [DATA_W-1:0]           ctrl_q;
    logic [DATA_W-1:0]           ps_q;
    logic [NCH-1:0][CNT_W-1:0]   per_q;
    logic [NCH-1:0][CNT_W-1:0]   duty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ps_q   <= '0;
            per_q  <= '0;
            duty_q <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(CTRL_ADDR)) ctrl_q <= wdata & CMASK;
            if (addr == ADDR_W'(PS_ADDR))   ps_q   <= wdata & PMASK;
            for (int c = 0; c < NCH; c++) begin
                if (addr == period_addr(c)) per_q[c]  <= wdata[CNT_W-1:0];
                if (addr == duty_addr(c))   duty_q[c] <= wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CTRL_ADDR)) rdata = ctrl_q;
        if (addr == ADDR_W'(PS_ADDR))   rdata = ps_q;
        for (int c = 0; c < NCH; c++) begin
            if (addr == period_addr(c)) rdata = DATA_W'(per_q[c]);
            if (addr == duty_addr(c))   rdata = DATA_W'(duty_q[c]);
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_fields
        assign trig[c]          = ctrl_q[TRIG_OFS + c];
        assign smooth[c]        = ctrl_q[SMOOTH_OFS + c];
        assign shadow[c].ps     = ps_q[4*c +: PS_W];
        assign shadow[c].period = per_q[c];
        assign shadow[c].duty   = duty_q[c];
        assign shadow[c].pol    = ctrl_q[POL_OFS + c];
    end

endmodule

// File: rtl/trig_pwm_commit.sv
module trig_pwm_commit
    import trig_pwm_pkg::*;
#(
    parameter int APPLY_LAT = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trig,
    input  logic       smooth,
    input  wave_cfg_t  shadow,
    input  logic       period_last,
    output logic       load,
    output logic       load_smooth,
    output logic       restart,
    output wave_cfg_t  pend_cfg
);

    localparam int CD_W = (APPLY_LAT > 1) ? $clog2(APPLY_LAT) : 1;

    logic            trig_q;
    logic            pend;
    logic            pend_smooth;
    logic [CD_W-1:0] cd;
    logic            rise;

    assign rise        = trig & ~trig_q;
    assign load        = pend & (pend_smooth ? period_last : (cd == '0));
    assign load_smooth = load & pend_smooth;
    assign restart     = load & ~pend_smooth;

    // A new trigger edge replaces any capture still waiting
    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q      <= 1'b0;
            pend        <= 1'b0;
            pend_smooth <= 1'b0;
            cd          <= '0;
            pend_cfg    <= '0;
        end else begin
            trig_q <= trig;
            if (rise) begin
                pend        <= 1'b1;
                pend_smooth <= smooth;
                pend_cfg    <= shadow;
                cd          <= CD_W'(APPLY_LAT - 1);
            end else if (load) begin
                pend <= 1'b0;
            end else if (pend && !pend_smooth && cd != '0) begin
                cd <= cd - 1'b1;
            end
        end
    end

endmodule

// File: rtl/trig_pwm_gen.sv
module trig_pwm_gen
    import trig_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             restart,
    input  wave_cfg_t        new_cfg,
    input  logic             force_high,
    output logic             period_last,
    output wave_cfg_t        act,
    output logic [CNT_W-1:0] cnt,
    output logic             pwm
);

    logic [PS_W-1:0] ps_cnt;
    logic            tick;
    logic            wave;

    assign tick        = (ps_cnt == act.ps);
    assign period_last = tick && ((CNT_W+1)'(cnt) + 1'b1 >= (CNT_W+1)'(act.period));
    assign wave        = (act.period >= CNT_W'(2)) && (cnt < act.duty);

    always_ff @(posedge clk) begin
        if (rst) begin
            act    <= '0;
            ps_cnt <= '0;
            cnt    <= '0;
            pwm    <= 1'b1;
        end else begin
            pwm <= force_high ? 1'b1 : (act.pol ? wave : ~wave);
            if (restart) begin
                ps_cnt <= '0;
                cnt    <= '0;
            end else begin
                ps_cnt <= tick ? '0 : ps_cnt + PS_W'(1);
                if (tick) cnt <= period_last ? '0 : cnt + CNT_W'(1);
            end
            if (load) act <= new_cfg;
        end
    end

endmodule

// File: rtl/trig_pwm_ctrl.sv
module trig_pwm_ctrl
    import trig_pwm_pkg::*;
#(
    parameter int NCH       = 6,
    parameter int APPLY_LAT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_out
);

    logic [NCH-1:0]            trig_bits;
    logic [NCH-1:0]            smooth_bits;
    wave_cfg_t [NCH-1:0]       shadow;
    wave_cfg_t [NCH-1:0]       pend_cfg;
    wave_cfg_t [NCH-1:0]       act_cfg;
    logic [NCH-1:0]            load_v;
    logic [NCH-1:0]            smooth_load_v;
    logic [NCH-1:0]            restart_v;
    logic [NCH-1:0]            last_v;
    logic [NCH-1:0]            act_pol;
    logic [NCH-1:0][CNT_W-1:0] act_period;
    logic [NCH-1:0][CNT_W-1:0] act_duty;
    logic [NCH-1:0][CNT_W-1:0] cnt_v;

    trig_pwm_regs #(.NCH(NCH)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .trig   (trig_bits),
        .smooth (smooth_bits),
        .shadow (shadow)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        trig_pwm_commit #(.APPLY_LAT(APPLY_LAT)) u_commit (
            .clk         (clk),
            .rst         (rst),
            .trig        (trig_bits[c]),
            .smooth      (smooth_bits[c]),
            .shadow      (shadow[c]),
            .period_last (last_v[c]),
            .load        (load_v[c]),
            .load_smooth (smooth_load_v[c]),
            .restart     (restart_v[c]),
            .pend_cfg    (pend_cfg[c])
        );

        trig_pwm_gen u_gen (
            .clk         (clk),
            .rst         (rst),
            .load        (load_v[c]),
            .restart     (restart_v[c]),
            .new_cfg     (pend_cfg[c]),
            .force_high  (~trig_bits[c] & ~smooth_bits[c]),
            .period_last (last_v[c]),
            .act         (act_cfg[c]),
            .cnt         (cnt_v[c]),
            .pwm         (pwm_out[c])
        );

        assign act_pol[c]    = act_cfg[c].pol;
        assign act_period[c] = act_cfg[c].period;
        assign act_duty[c]   = act_cfg[c].duty;
    end

endmodule

// File: rtl/trig_pwm_chk.sv
module trig_pwm_chk
    import trig_pwm_pkg::*;
#(
    parameter int NCH = 6
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NCH-1:0]        trig_bits,
    input logic [NCH-1:0]        smooth_bits,
    input logic [NCH-1:0]        pwm_out,
    input logic [NCH-1:0]        load_v,
    input logic [NCH-1:0]        smooth_load_v,
    input logic [NCH-1:0]        last_v,
    input logic [NCH-1:0]        act_pol,
    input logic [NCH-1:0][CNT_W-1:0] act_period,
    input logic [NCH-1:0][CNT_W-1:0] act_duty,
    input logic [NCH-1:0][CNT_W-1:0] cnt_v
);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
            (!trig_bits[c] && !smooth_bits[c]) |=> pwm_out[c]); // R8

        AST_NO_EARLY_APPLY: assert property (@(posedge clk) disable iff (rst)
            !load_v[c] |=> ($stable(act_period[c]) && $stable(act_duty[c]) && $stable(act_pol[c]))); // R5

        AST_SMOOTH_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
            smooth_load_v[c] |-> last_v[c]); // R7

        AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
            (act_period[c] >= CNT_W'(2)) |-> (cnt_v[c] < act_period[c])); // R3

        AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst)
            ((trig_bits[c] || smooth_bits[c]) && act_duty[c] == '0 && act_pol[c]) |=> !pwm_out[c]); // R4
    end

endmodule

bind trig_pwm_ctrl trig_pwm_chk #(.NCH(NCH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .trig_bits     (trig_bits),
    .smooth_bits   (smooth_bits),
    .pwm_out       (pwm_out),
    .load_v        (load_v),
    .smooth_load_v (smooth_load_v),
    .last_v        (last_v),
    .act_pol       (act_pol),
    .act_period    (act_period),
    .act_duty      (act_duty),
    .cnt_v         (cnt_v)
);

// File: tb/trig_pwm_ctrl_tb.sv
module trig_pwm_ctrl_tb;

    localparam int NCH = 6;
    localparam int LAT = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] pwm_out;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int hi_cnt [NCH];
    logic [31:0] ctrl_m = '0;
    logic [31:0] ps_m = '0;

    trig_pwm_ctrl #(.NCH(NCH), .APPLY_LAT(LAT)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic measure(input int win);
        for (int c = 0; c < NCH; c++) hi_cnt[c] = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) if (pwm_out[c]) hi_cnt[c]++;
        end
    endtask

    task automatic set_ctrl(input int ch, input bit trg, input bit smo, input bit pol);
        ctrl_m[ch]      = trg;
        ctrl_m[24 + ch] = smo;
        ctrl_m[8 + ch]  = pol;
        wr(8'h00, ctrl_m);
    endtask

    // Load shadow values and commit them with an immediate trigger edge
    task automatic apply_imm(input int ch, input int s, input int p, input int d, input bit pol);
        set_ctrl(ch, 0, 1, pol);
        ps_m[4*ch +: 3] = 3'(s);
        wr(8'h04, ps_m);
        wr(8'(8 + 8*ch), 32'(p));
        wr(8'(12 + 8*ch), 32'(d));
        set_ctrl(ch, 1, 0, pol);
        repeat (LAT + 3) @(negedge clk);
    endtask

    function automatic int exp_hi(input int s, input int p, input int d, input int win);
        int h;
        if (p < 2) return 0;
        h = (d < p) ? d : p;
        return (win / ((s + 1) * p)) * (s + 1) * h;
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 pwm_out during reset", pwm_out, 6'h3F);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pwm_out after reset", pwm_out, 6'h3F);
        rd(8'h00, d); check("R1 ctrl reset", d, 0);
        rd(8'h04, d); check("R1 prescale reset", d, 0);
        for (int c = 0; c < NCH; c++) begin
            rd(8'(8 + 8*c), d);  check("R1 period reset", d, 0);
            rd(8'(12 + 8*c), d); check("R1 duty reset", d, 0);
        end

        // R2: register map and read-back masks
        @(negedge clk);
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check("R2 ctrl mask", d, 32'h3F3F_3F3F);
        wr(8'h00, 32'h0001_0000); rd(8'h00, d); check("R2 ctrl type bit", d, 32'h0001_0000);
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); check("R2 prescale mask", d, 32'h0077_7777);
        wr(8'h04, 32'h0012_3456); rd(8'h04, d); check("R2 prescale fields", d, 32'h0012_3456);
        for (int c = 0; c < NCH; c++) begin
            wr(8'(8 + 8*c), 32'hFF00_0000 | 32'(c * 32'h111)); rd(8'(8 + 8*c), d);
            check("R2 period readback", d, c * 32'h111);
            wr(8'(12 + 8*c), 32'hA5FF_FFF0 | 32'(c)); rd(8'(12 + 8*c), d);
            check("R2 duty readback", d, 32'h00FF_FFF0 | 32'(c));
        end
        rd(8'h40, d); check("R2 unmapped read", d, 0);
        wr(8'h00, 32'h0); ctrl_m = '0;
        wr(8'h04, 32'h0); ps_m = '0;
        @(negedge clk);
        check("R8 all forced high", pwm_out, 6'h3F);

        // R3 R4: sweep prescale, period, duty on channel 0
        for (int s = 0; s < 3; s++)
            for (int p = 0; p < 6; p++)
                for (int dd = 0; dd < 7; dd++) begin
                    int win;
                    win = 2 * (s + 1) * ((p < 2) ? 2 : p);
                    apply_imm(0, s, p, dd, 1);
                    measure(win);
                    check((p < 2 || dd == 0 || dd >= p) ? "R4 degenerate high count" : "R3 high count",
                          hi_cnt[0], exp_hi(s, p, dd, win));
                    check("R10 idle channel stays high", hi_cnt[1], win);
                end

        // R9: inverted polarity
        for (int dd = 0; dd < 6; dd++) begin
            apply_imm(0, 1, 4, dd, 0);
            measure(16);
            check("R9 inverted high count", hi_cnt[0], 16 - exp_hi(1, 4, dd, 16));
        end

        // R5: shadow writes without trigger edge
        apply_imm(0, 0, 4, 1, 1);
        wr(8'h08, 32'd6);
        wr(8'h0C, 32'd5);
        ps_m[2:0] = 3'd2; wr(8'h04, ps_m);
        set_ctrl(0, 1, 1, 0);
        measure(16);
        check("R5 shadow writes ignored", hi_cnt[0], 4);
        set_ctrl(0, 0, 1, 0);
        measure(16);
        check("R5 trigger fall ignored", hi_cnt[0], 4);

        // R8: forced high and resume
        set_ctrl(0, 0, 0, 1);
        @(negedge clk);
        measure(16);
        check("R8 forced high", hi_cnt[0], 16);
        set_ctrl(0, 0, 1, 1);
        @(negedge clk);
        measure(16);
        check("R8 resume committed waveform", hi_cnt[0], 4);

        // R6: immediate latency and restart
        ps_m[2:0] = 3'd0; wr(8'h04, ps_m);
        apply_imm(0, 0, 10, 0, 1);
        set_ctrl(0, 0, 1, 1);
        wr(8'h0C, 32'd5);
        set_ctrl(0, 1, 0, 1);
        for (int k = 1; k <= LAT + 11; k++) begin
            int e;
            @(negedge clk);
            e = (k < LAT + 2) ? 0 : ((k - (LAT + 2)) < 5 ? 1 : 0);
            check($sformatf("R6 latency edge %0d", k), pwm_out[0], e);
        end

        // R7: smooth commit lands on the period wrap
        set_ctrl(0, 0, 1, 1);
        wr(8'h08, 32'd20);
        wr(8'h0C, 32'd0);
        set_ctrl(0, 1, 0, 1);
        repeat (LAT + 3) @(negedge clk);
        wr(8'h0C, 32'd20);
        set_ctrl(0, 0, 1, 1);
        set_ctrl(0, 1, 1, 1);
        for (int k = LAT + 7; k <= LAT + 26; k++) begin
            @(negedge clk);
            check($sformatf("R7 smooth edge %0d", k), pwm_out[0], (k < LAT + 22) ? 0 : 1);
        end

        // R10: two channels committed independently
        apply_imm(0, 0, 4, 1, 1);
        apply_imm(5, 1, 3, 2, 1);
        measure(24);
        check("R10 channel 0", hi_cnt[0], 6);
        check("R10 channel 5", hi_cnt[5], 16);
        check("R10 channel 3 forced", hi_cnt[3], 24);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule